// File: doc/BRIEF.md
# Variable-Length Instruction Field Decoder

This block inspects the leading two bytes of a variable-length instruction and recognises the instruction format. It also pulls out the fields that steer the operands: an operation class, the operand-width bit, the direction bit, two register numbers and the addressing-mode field. It computes the total instruction length in bytes, including any displacement or immediate bytes that follow, so that a fetch unit can advance its instruction pointer without decoding the instruction itself.

Five formats are recognised:

- the register/memory move;
- the register/memory add;
- the general register/memory increment;
- the single-byte register increment;
- the move-immediate-to-register form.

Any other leading byte, and a general increment whose second byte does not carry the increment sub-code, is flagged as illegal with a length of one byte.

A fetch unit presents the window with a valid strobe. One clock later the decoded fields appear with their own valid strobe. While no window is presented, the decoded fields hold their last values.

Top module: `vld_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero after that edge.
- R2: `dec_valid` equals the `win_valid` of the previous cycle. When `win_valid` is low, all other outputs keep their values.
- R3: `dec_class` encodes the leading byte (byte 0 = `win_bytes[7:0]`, byte 1 = `win_bytes[15:8]`) as follows:
  - 1 for a register/memory move, byte 0 = 100010dw;
  - 2 for a register/memory add, byte 0 = 000000dw;
  - 3 for a general increment, byte 0 = 1111111w with byte 1 bits [5:3] equal to 000;
  - 4 for a short increment, byte 0 = 01000rrr;
  - 5 for a move-immediate-to-register, byte 0 = 1011wrrr;
  - 0 for anything else.
- R4: The width and direction bits are set per format:
  - move and add: `dec_wide` = byte 0 bit 0 and `dec_dir` = byte 0 bit 1;
  - general increment: `dec_wide` = byte 0 bit 0 and `dec_dir` = 0;
  - short increment: `dec_wide` = 1 and `dec_dir` = 1;
  - move immediate: `dec_wide` = byte 0 bit 3 and `dec_dir` = 1.
- R5: For the three formats that use a second byte, `dec_mod`, `dec_reg` and `dec_rm` are byte 1 bits [7:6], [5:3] and [2:0]. For the two one-byte-opcode forms, `dec_reg` is byte 0 bits [2:0], `dec_mod` is 11 and `dec_rm` is 000.
- R6: For the three formats that use a second byte, `dec_len` is 2 plus the displacement size. The displacement is 1 byte for mod 01, 2 bytes for mod 10, and 0 bytes for mod 11 or for mod 00 with any R/M other than 110.
- R7: With mod 00 and R/M 110 (direct address), `dec_len` is 4.
- R8: The short increment has `dec_len` 1. The move immediate has `dec_len` 2 when its width bit is 0 and 3 when it is 1.
- R9: An unrecognised window gives the following outputs:
  - `dec_illegal` = 1, `dec_class` = 0 and `dec_len` = 1;
  - width, direction, REG, R/M and MOD all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_valid | input | 1 | Window holds the start of an instruction |
| win_bytes | input | 16 | Byte 0 in [7:0], byte 1 in [15:8] |
| dec_valid | output | 1 | Decoded fields valid |
| dec_class | output | 3 | Operation class code |
| dec_wide | output | 1 | 1 = word operands, 0 = byte operands |
| dec_dir | output | 1 | 1 = REG register is destination |
| dec_reg | output | 3 | REG register number |
| dec_rm | output | 3 | R/M field |
| dec_mod | output | 2 | Addressing-mode field |
| dec_len | output | 3 | Instruction length in bytes |
| dec_illegal | output | 1 | Window not a supported format |

## Verification
The assertions assume that `win_bytes` is meaningful only while `win_valid` is high. They also assume that the byte following the leading byte is always present in the window, even for one-byte forms, where it is ignored. Consequently the length properties only relate `dec_len` to the class and mode fields of the same decode. The stimulus draws leading bytes from buckets aimed at each format and at unused opcode space, pairs them with arbitrary second bytes, and inserts idle cycles carrying junk bytes so that the hold behaviour is exercised.

// File: rtl/vld_pkg.sv
// Package: shared types and widths for the instruction field decoder.
// Assumes a two-byte window: the leading opcode byte and the byte after it.
package vld_pkg;
    localparam int BYTE_W  = 8;
    localparam int WIN_N   = 2;
    localparam int WIN_W   = BYTE_W * WIN_N;
    localparam int MAX_LEN = 6;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int REG_W   = 3;
    localparam int MOD_W   = 2;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_MOV_RM  = 3'd1,
        CLS_ADD_RM  = 3'd2,
        CLS_INC_RM  = 3'd3,
        CLS_INC_REG = 3'd4,
        CLS_MOV_IMM = 3'd5
    } vld_class_e;

    typedef struct packed {
        vld_class_e        cls;
        logic              wide;
        logic              dir;
        logic [REG_W-1:0]  reg_n;
        logic [REG_W-1:0]  rm;
        logic [MOD_W-1:0]  mod;
        logic [LEN_W-1:0]  len;
        logic              illegal;
    } vld_fields_t;
endpackage

// File: rtl/vld_opcode_match.sv
// Module: classifies the leading byte (and, for the general increment, the
// sub-code in the second byte) into one of the supported formats.
// Assumes both bytes are present; purely combinational.
module vld_opcode_match
    import vld_pkg::*;
(
    input  logic [BYTE_W-1:0] op_byte,
    input  logic [BYTE_W-1:0] ext_byte,
    output vld_class_e        cls
);
    // Purpose: pattern-match the opcode byte against each format.
    always_comb begin
        cls = CLS_NONE;
        if (op_byte[7:2] == 6'b100010)
            cls = CLS_MOV_RM;
        else if (op_byte[7:2] == 6'b000000)
            cls = CLS_ADD_RM;
        else if (op_byte[7:1] == 7'b1111111 && ext_byte[5:3] == 3'b000)
            cls = CLS_INC_RM;
        else if (op_byte[7:3] == 5'b01000)
            cls = CLS_INC_REG;
        else if (op_byte[7:4] == 4'b1011)
            cls = CLS_MOV_IMM;
    end
endmodule

// File: rtl/vld_field_extract.sv
// Module: pulls width, direction and register fields out of the window
// according to the matched format. Illegal windows yield all-zero fields.
// Assumes cls was produced from the same window; purely combinational.
module vld_field_extract
    import vld_pkg::*;
(
    input  vld_class_e        cls,
    input  logic [BYTE_W-1:0] op_byte,
    input  logic [BYTE_W-1:0] ext_byte,
    output logic              wide,
    output logic              dir,
    output logic [REG_W-1:0]  reg_n,
    output logic [REG_W-1:0]  rm,
    output logic [MOD_W-1:0]  mod
);
    // Purpose: route fields from byte 0 or the mode byte per format.
    always_comb begin
        wide  = 1'b0;
        dir   = 1'b0;
        reg_n = '0;
        rm    = '0;
        mod   = '0;
        unique case (cls)
            CLS_MOV_RM, CLS_ADD_RM: begin
                wide  = op_byte[0];
                dir   = op_byte[1];
                mod   = ext_byte[7:6];
                reg_n = ext_byte[5:3];
                rm    = ext_byte[2:0];
            end
            CLS_INC_RM: begin
                wide  = op_byte[0];
                mod   = ext_byte[7:6];
                reg_n = ext_byte[5:3];
                rm    = ext_byte[2:0];
            end
            CLS_INC_REG: begin
                wide  = 1'b1;
                dir   = 1'b1;
                reg_n = op_byte[2:0];
                mod   = 2'b11;
            end
            CLS_MOV_IMM: begin
                wide  = op_byte[3];
                dir   = 1'b1;
                reg_n = op_byte[2:0];
                mod   = 2'b11;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vld_length_calc.sv
// Module: computes total instruction length from the format, width bit
// and addressing-mode fields. Assumes fields came from vld_field_extract.
module vld_length_calc
    import vld_pkg::*;
(
    input  vld_class_e       cls,
    input  logic             wide,
    input  logic [MOD_W-1:0] mod,
    input  logic [REG_W-1:0] rm,
    output logic [LEN_W-1:0] len
);
    logic [LEN_W-1:0] disp_n;

    // Purpose: displacement bytes implied by the mode byte.
    always_comb begin
        unique case (mod)
            2'b00:   disp_n = (rm == 3'b110) ? LEN_W'(2) : LEN_W'(0);
            2'b01:   disp_n = LEN_W'(1);
            2'b10:   disp_n = LEN_W'(2);
            default: disp_n = LEN_W'(0);
        endcase
    end

    // Purpose: sum opcode, mode byte, displacement and immediate bytes.
    always_comb begin
        unique case (cls)
            CLS_MOV_RM, CLS_ADD_RM, CLS_INC_RM: len = LEN_W'(2) + disp_n;
            CLS_MOV_IMM: len = wide ? LEN_W'(3) : LEN_W'(2);
            default:     len = LEN_W'(1);
        endcase
    end
endmodule

// File: rtl/vld_decoder.sv
// Module: top of the instruction field decoder. Combines format match,
// field extraction and length computation, then registers the result.
// Assumes win_bytes is meaningful only while win_valid is high.
// Outputs hold while no window is presented.
module vld_decoder
    import vld_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [15:0]      win_bytes,
    output logic             dec_valid,
    output logic [2:0]       dec_class,
    output logic             dec_wide,
    output logic             dec_dir,
    output logic [2:0]       dec_reg,
    output logic [2:0]       dec_rm,
    output logic [1:0]       dec_mod,
    output logic [2:0]       dec_len,
    output logic             dec_illegal
);
    logic [WIN_N-1:0][BYTE_W-1:0] win_split;
    vld_class_e  cls_c;
    vld_fields_t nxt, cur;
    logic        valid_q;

    assign win_split = win_bytes;

    vld_opcode_match u_match (
        .op_byte (win_split[0]),
        .ext_byte(win_split[1]),
        .cls     (cls_c)
    );

    vld_field_extract u_fields (
        .cls     (cls_c),
        .op_byte (win_split[0]),
        .ext_byte(win_split[1]),
        .wide    (nxt.wide),
        .dir     (nxt.dir),
        .reg_n   (nxt.reg_n),
        .rm      (nxt.rm),
        .mod     (nxt.mod)
    );

    vld_length_calc u_len (
        .cls (cls_c),
        .wide(nxt.wide),
        .mod (nxt.mod),
        .rm  (nxt.rm),
        .len (nxt.len)
    );

    assign nxt.cls     = cls_c;
    assign nxt.illegal = (cls_c == CLS_NONE);

    // Purpose: output register, loaded only when a window is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= win_valid;
            if (win_valid) cur <= nxt;
        end
    end

    assign dec_valid   = valid_q;
    assign dec_class   = cur.cls;
    assign dec_wide    = cur.wide;
    assign dec_dir     = cur.dir;
    assign dec_reg     = cur.reg_n;
    assign dec_rm      = cur.rm;
    assign dec_mod     = cur.mod;
    assign dec_len     = cur.len;
    assign dec_illegal = cur.illegal;

    // R2: output valid tracks the input strobe one cycle later.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> dec_valid);
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> !dec_valid);
    // R2: the length holds while idle.
    a_r2_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> $stable(dec_len));
    // R9: an illegal decode reports class 0 and a single byte.
    a_r9_illegal_len: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_illegal |-> (dec_len == 3'd1 && dec_class == 3'd0));
    // R8: the short increment is one byte long.
    a_r8_short_len: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_class == 3'd4 |-> dec_len == 3'd1);
    // R6: register-to-register forms carry no displacement.
    a_r6_regmode_len: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && (dec_class == 3'd1 || dec_class == 3'd2 || dec_class == 3'd3)
        && dec_mod == 2'b11 |-> dec_len == 3'd2);
    // R7: direct addressing always takes a 16-bit displacement.
    a_r7_direct_len: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && (dec_class == 3'd1 || dec_class == 3'd2 || dec_class == 3'd3)
        && dec_mod == 2'b00 && dec_rm == 3'b110 |-> dec_len == 3'd4);
endmodule

// File: tb/vld_decoder_bench.sv
`timescale 1ns/1ps
module vld_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_valid = 1'b0;
    logic [15:0] win_bytes = '0;
    logic        dec_valid, dec_wide, dec_dir, dec_illegal;
    logic [2:0]  dec_class, dec_reg, dec_rm, dec_len;
    logic [1:0]  dec_mod;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vld_decoder u_vld_decoder (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_bytes(win_bytes),
        .dec_valid(dec_valid), .dec_class(dec_class), .dec_wide(dec_wide),
        .dec_dir(dec_dir), .dec_reg(dec_reg), .dec_rm(dec_rm),
        .dec_mod(dec_mod), .dec_len(dec_len), .dec_illegal(dec_illegal)
    );

    // Expected values, written from the requirements.
    int e_cls, e_wide, e_dir, e_reg, e_rm, e_mod, e_len, e_ill;

    function automatic void model(input logic [7:0] b0, input logic [7:0] b1);
        int disp;
        e_cls = 0; e_wide = 0; e_dir = 0; e_reg = 0; e_rm = 0; e_mod = 0;
        e_len = 1; e_ill = 0;
        if (b0[7:2] == 6'b100010)                          e_cls = 1;
        else if (b0[7:2] == 6'b000000)                     e_cls = 2;
        else if (b0[7:1] == 7'h7F && b1[5:3] == 3'b000)    e_cls = 3;
        else if (b0[7:3] == 5'b01000)                      e_cls = 4;
        else if (b0[7:4] == 4'b1011)                       e_cls = 5;
        if (e_cls >= 1 && e_cls <= 3) begin
            e_wide = b0[0];
            e_dir  = (e_cls == 3) ? 0 : b0[1];
            e_mod  = b1[7:6]; e_reg = b1[5:3]; e_rm = b1[2:0];
            if (e_mod == 1) disp = 1;
            else if (e_mod == 2) disp = 2;
            else if (e_mod == 0 && e_rm == 6) disp = 2;
            else disp = 0;
            e_len = 2 + disp;
        end else if (e_cls == 4) begin
            e_wide = 1; e_dir = 1; e_reg = b0[2:0]; e_mod = 3; e_len = 1;
        end else if (e_cls == 5) begin
            e_wide = b0[3]; e_dir = 1; e_reg = b0[2:0]; e_mod = 3;
            e_len = b0[3] ? 3 : 2;
        end else begin
            e_ill = 1;
        end
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic decode(input logic [7:0] b0, input logic [7:0] b1);
        string ltag;
        @(negedge clk);
        win_valid = 1'b1;
        win_bytes = {b1, b0};
        model(b0, b1);
        @(negedge clk);
        win_valid = 1'b0;
        win_bytes = 16'hA5A5;
        if (e_ill != 0) ltag = "R9 len";
        else if (e_cls >= 4) ltag = "R8 len";
        else if (e_mod == 0 && e_rm == 6) ltag = "R7 len";
        else ltag = "R6 len";
        chk("R2 valid", dec_valid, 1);
        chk("R3 class", dec_class, e_cls);
        chk("R4 wide", dec_wide, e_wide);
        chk("R4 dir", dec_dir, e_dir);
        chk("R5 reg", dec_reg, e_reg);
        chk("R5 rm", dec_rm, e_rm);
        chk("R5 mod", dec_mod, e_mod);
        chk(ltag, dec_len, e_len);
        chk("R9 illegal", dec_illegal, e_ill);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd317));
        win_valid = 1'b1;
        win_bytes = 16'h0488;
        repeat (3) @(negedge clk);
        // R1: reset clears everything even with a window presented.
        chk("R1 valid", dec_valid, 0);
        chk("R1 class", dec_class, 0);
        chk("R1 len", dec_len, 0);
        chk("R1 illegal", dec_illegal, 0);
        chk("R1 reg", dec_reg, 0);
        win_valid = 1'b0;
        rst_n = 1'b1;

        decode(8'h41, 8'hFF);   // R8 short increment
        decode(8'h88, 8'hC3);   // register move
        decode(8'h03, 8'h04);   // add from memory
        decode(8'hFE, 8'hC1);   // general increment
        decode(8'hFE, 8'hC9);   // R9 wrong sub-code
        decode(8'hB0, 8'h00);   // R8 byte immediate
        decode(8'hBB, 8'h00);   // R8 word immediate
        decode(8'h8B, 8'h06);   // R7 direct address
        decode(8'h8A, 8'h44);   // R6 8-bit displacement
        decode(8'h01, 8'h87);   // R6 16-bit displacement
        decode(8'h0F, 8'h00);   // R9 unused opcode

        // R2: idle cycles keep outputs, even with junk bytes.
        @(negedge clk);
        win_bytes = 16'h06FF;
        @(negedge clk);
        chk("R2 idle valid", dec_valid, 0);
        chk("R2 hold len", dec_len, 1);
        chk("R2 hold illegal", dec_illegal, 1);

        for (int i = 0; i < 400; i++) begin
            logic [7:0] b0, b1;
            b1 = 8'($urandom);
            case ($urandom % 6)
                0: b0 = {6'b100010, 2'($urandom)};
                1: b0 = {6'b000000, 2'($urandom)};
                2: b0 = {7'h7F, 1'($urandom)};
                3: b0 = {5'b01000, 3'($urandom)};
                4: b0 = {4'b1011, 4'($urandom)};
                default: b0 = 8'($urandom);
            endcase
            decode(b0, b1);
            if (($urandom % 4) == 0) @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule